// File: doc/BRIEF.md
# DMA Event Status Register

This block collects the event pulses produced by the transmit and receive DMA engines of an Ethernet MAC and holds each event in a sticky status bit until software clears it. Software clears a bit by writing 1 to its position; writing 0 leaves it alone. A single interrupt line is high whenever any event bit is set. When the hardware sets a bit in the same cycle that software clears it, the set wins, so no event is lost.

Two small state machines sit beside the sticky bits. The receive descriptor qualifier has the states ARMED and BLOCKED. It starts in ARMED. A fetch of a DMA-owned descriptor moves it to ARMED, or keeps it there. A fetch of a host-owned descriptor moves it to BLOCKED. The receive-buffer-unavailable event is raised only on the ARMED-to-BLOCKED transition, so a run of host-owned fetches raises it once. The transmit suspend tracker has the states RUN and HELD. An underflow pulse moves it from RUN to HELD. A clearing write to the underflow bit with no new underflow moves it from HELD back to RUN. In HELD it drives the suspend request. The live 3-bit transmit process state is mirrored read-only into the register.

Top module: `dma_evt_status`

## Requirements
- R1: After reset all event bits (positions 9..0) read 0, and `irq` and `tx_suspend_req` are low.
- R2: A write sets `reg_wr` with `reg_wdata`. The write clears every event bit whose `reg_wdata` bit is 1, and the cleared bit reads 0 from the next cycle. Bits written with 0 keep their value.
- R3: When an event pulse and a clearing write reach the same bit in the same cycle, the bit reads 1 after that edge.
- R4: An event pulse in cycle n sets its bit, and the bit reads 1 from cycle n+1. The bit positions are: 0 transmit done, 1 transmit stopped, 2 transmit buffer unavailable, 3 transmit jabber, 4 receive overflow, 5 transmit underflow, 6 receive done, 7 receive buffer unavailable, 8 receive stopped, 9 receive watchdog timeout.
- R5: A descriptor fetch (`rx_fetch_p`) with `rx_fetch_dma_own`=0 sets bit 7 only if the previous fetch was DMA-owned, or if it is the first fetch after reset. Further host-owned fetches in a row do not set bit 7 again.
- R6: `irq` equals the OR of bits 9..0.
- R7: Bits 22..20 read the current `tx_state` in the same cycle, and writes to these bits have no effect.
- R8: Bits 31..23 and 19..10 read 0 whatever is written.
- R9: A transmit underflow pulse raises `tx_suspend_req` at the same edge at which it sets bit 5. `tx_suspend_req` stays high until a clearing write to bit 5 is made with no new underflow pulse in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done_p | input | 1 | Transmit frame complete pulse |
| tx_stop_p | input | 1 | Transmit process stopped pulse |
| tx_bufna_p | input | 1 | Transmit buffer unavailable pulse |
| tx_jabber_p | input | 1 | Transmit jabber timeout pulse |
| rx_ovf_p | input | 1 | Receive overflow pulse |
| tx_unf_p | input | 1 | Transmit underflow pulse |
| rx_done_p | input | 1 | Receive frame complete pulse |
| rx_fetch_p | input | 1 | Receive descriptor fetched pulse |
| rx_fetch_dma_own | input | 1 | Ownership of the fetched descriptor (1 = DMA) |
| rx_stop_p | input | 1 | Receive process stopped pulse |
| rx_wdt_p | input | 1 | Receive watchdog timeout pulse |
| tx_state | input | 3 | Live transmit process state code |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data (1 clears the bit) |
| reg_rdata | output | 32 | Register read value |
| irq | output | 1 | Interrupt, high while any event bit is set |
| tx_suspend_req | output | 1 | Transmit suspend request after an underflow |

## Verification
The hardest cases to reach are the ones that depend on history and on collisions: the receive-buffer-unavailable bit depends on the ownership of the previous fetch, and set-versus-clear only shows up when both land on one edge. The stimulus clears bit 7 between host-owned fetches, so that a second raise would be seen. It then fetches a DMA-owned descriptor to re-arm the qualifier. Table rows drive an event and a write-1 to the same bit in one cycle, and the underflow row is later cleared to show the suspend request dropping.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
    localparam int EVT_N       = 10;
    localparam int BIT_TX_DONE = 0;
    localparam int BIT_TX_STOP = 1;
    localparam int BIT_TX_BUFNA = 2;
    localparam int BIT_TX_JAB  = 3;
    localparam int BIT_RX_OVF  = 4;
    localparam int BIT_TX_UNF  = 5;
    localparam int BIT_RX_DONE = 6;
    localparam int BIT_RX_BUFNA = 7;
    localparam int BIT_RX_STOP = 8;
    localparam int BIT_RX_WDT  = 9;

    typedef enum logic {
        RBU_ARMED   = 1'b0,
        RBU_BLOCKED = 1'b1
    } rbu_state_e;

    typedef enum logic {
        SUS_RUN  = 1'b0,
        SUS_HELD = 1'b1
    } sus_state_e;
endpackage

// File: rtl/dma_evt_bitcell.sv
module dma_evt_bitcell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else begin
            q_o <= set_i | (q_o & ~clr_i);
        end
    end
endmodule

// File: rtl/dma_evt_rbu_fsm.sv
module dma_evt_rbu_fsm
    import dma_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_p,
    input  logic dma_own,
    output logic rbu_evt
);
    rbu_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (fetch_p) begin
            unique case (state_q)
                RBU_ARMED:   state_d = dma_own ? RBU_ARMED : RBU_BLOCKED;
                RBU_BLOCKED: state_d = dma_own ? RBU_ARMED : RBU_BLOCKED;
                default:     state_d = RBU_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RBU_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rbu_evt = 1'b0;
        unique case (state_q)
            RBU_ARMED:   rbu_evt = fetch_p & ~dma_own;
            RBU_BLOCKED: rbu_evt = 1'b0;
            default:     rbu_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_evt_susp_fsm.sv
module dma_evt_susp_fsm
    import dma_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic unf_p,
    input  logic unf_clr,
    output logic suspend_req
);
    sus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUS_RUN:  if (unf_p) state_d = SUS_HELD;
            SUS_HELD: if (unf_clr && !unf_p) state_d = SUS_RUN;
            default:  state_d = SUS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SUS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SUS_RUN:  suspend_req = 1'b0;
            SUS_HELD: suspend_req = 1'b1;
            default:  suspend_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_evt_status.sv
module dma_evt_status
    import dma_evt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int STATE_W   = 3,
    parameter int STATE_LSB = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_done_p,
    input  logic               tx_stop_p,
    input  logic               tx_bufna_p,
    input  logic               tx_jabber_p,
    input  logic               rx_ovf_p,
    input  logic               tx_unf_p,
    input  logic               rx_done_p,
    input  logic               rx_fetch_p,
    input  logic               rx_fetch_dma_own,
    input  logic               rx_stop_p,
    input  logic               rx_wdt_p,
    input  logic [STATE_W-1:0] tx_state,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq,
    output logic               tx_suspend_req
);
    localparam int EV = EVT_N;

    logic [EV-1:0] evt_set;
    logic [EV-1:0] clr_vec;
    logic [EV-1:0] status;
    logic          rbu_evt;
    logic          unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:EV];

    dma_evt_rbu_fsm u_rbu (
        .clk     (clk),
        .rst_n   (rst_n),
        .fetch_p (rx_fetch_p),
        .dma_own (rx_fetch_dma_own),
        .rbu_evt (rbu_evt)
    );

    always_comb begin
        evt_set               = '0;
        evt_set[BIT_TX_DONE]  = tx_done_p;
        evt_set[BIT_TX_STOP]  = tx_stop_p;
        evt_set[BIT_TX_BUFNA] = tx_bufna_p;
        evt_set[BIT_TX_JAB]   = tx_jabber_p;
        evt_set[BIT_RX_OVF]   = rx_ovf_p;
        evt_set[BIT_TX_UNF]   = tx_unf_p;
        evt_set[BIT_RX_DONE]  = rx_done_p;
        evt_set[BIT_RX_BUFNA] = rbu_evt;
        evt_set[BIT_RX_STOP]  = rx_stop_p;
        evt_set[BIT_RX_WDT]   = rx_wdt_p;
    end

    assign clr_vec = reg_wr ? reg_wdata[EV-1:0] : '0;

    for (genvar i = 0; i < EV; i++) begin : g_cell
        dma_evt_bitcell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_set[i]),
            .clr_i (clr_vec[i]),
            .q_o   (status[i])
        );
    end

    dma_evt_susp_fsm u_susp (
        .clk         (clk),
        .rst_n       (rst_n),
        .unf_p       (tx_unf_p),
        .unf_clr     (clr_vec[BIT_TX_UNF]),
        .suspend_req (tx_suspend_req)
    );

    always_comb begin
        reg_rdata                        = '0;
        reg_rdata[EV-1:0]                = status;
        reg_rdata[STATE_LSB +: STATE_W]  = tx_state;
    end

    assign irq = |status;
endmodule

// File: rtl/dma_evt_status_chk.sv
module dma_evt_status_chk #(
    parameter int DATA_W    = 32,
    parameter int STATE_W   = 3,
    parameter int STATE_LSB = 20,
    parameter int EV        = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_unf_p,
    input logic [STATE_W-1:0] tx_state,
    input logic               reg_wr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq,
    input logic               tx_suspend_req,
    input logic [EV-1:0]      evt_set
);
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ((reg_rdata[EV-1:0] & $past(reg_wdata[EV-1:0]) & ~$past(evt_set)) == '0)); // R2

    AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((reg_rdata[EV-1:0] & $past(reg_rdata[EV-1:0])) == $past(reg_rdata[EV-1:0]))); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((reg_rdata[EV-1:0] & $past(evt_set)) == $past(evt_set))); // R3

    AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (reg_rdata[EV-1:0] != '0)); // R6

    AST_STATE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[STATE_LSB +: STATE_W] == tx_state); // R7

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:STATE_LSB+STATE_W] == '0) && (reg_rdata[STATE_LSB-1:EV] == '0)); // R8

    AST_UNF_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_unf_p |=> (tx_suspend_req && reg_rdata[5])); // R9
endmodule

bind dma_evt_status dma_evt_status_chk #(
    .DATA_W    (DATA_W),
    .STATE_W   (STATE_W),
    .STATE_LSB (STATE_LSB),
    .EV        (EV)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_unf_p       (tx_unf_p),
    .tx_state       (tx_state),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .irq            (irq),
    .tx_suspend_req (tx_suspend_req),
    .evt_set        (evt_set)
);

// File: tb/tb_dma_evt_status.sv
module tb_dma_evt_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_done_p = 0, tx_stop_p = 0, tx_bufna_p = 0, tx_jabber_p = 0;
    logic        rx_ovf_p = 0, tx_unf_p = 0, rx_done_p = 0, rx_fetch_p = 0;
    logic        rx_fetch_dma_own = 0, rx_stop_p = 0, rx_wdt_p = 0;
    logic [2:0]  tx_state = 3'd0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tx_suspend_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_evt_status dut (
        .clk(clk), .rst_n(rst_n),
        .tx_done_p(tx_done_p), .tx_stop_p(tx_stop_p), .tx_bufna_p(tx_bufna_p),
        .tx_jabber_p(tx_jabber_p), .rx_ovf_p(rx_ovf_p), .tx_unf_p(tx_unf_p),
        .rx_done_p(rx_done_p), .rx_fetch_p(rx_fetch_p),
        .rx_fetch_dma_own(rx_fetch_dma_own), .rx_stop_p(rx_stop_p),
        .rx_wdt_p(rx_wdt_p), .tx_state(tx_state), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_suspend_req(tx_suspend_req)
    );

    // {events[9:0] (bit 7 unused), wr, clear mask[9:0], expected status[9:0]}
    localparam logic [30:0] VEC [16] = '{
        {10'h001, 1'b0, 10'h000, 10'h001},
        {10'h002, 1'b0, 10'h000, 10'h003},
        {10'h004, 1'b0, 10'h000, 10'h007},
        {10'h008, 1'b0, 10'h000, 10'h00F},
        {10'h010, 1'b0, 10'h000, 10'h01F},
        {10'h020, 1'b0, 10'h000, 10'h03F},
        {10'h040, 1'b0, 10'h000, 10'h07F},
        {10'h100, 1'b0, 10'h000, 10'h17F},
        {10'h200, 1'b0, 10'h000, 10'h37F},
        {10'h000, 1'b1, 10'h000, 10'h37F},
        {10'h000, 1'b1, 10'h00F, 10'h370},
        {10'h001, 1'b1, 10'h001, 10'h371},
        {10'h000, 1'b1, 10'h3FF, 10'h000},
        {10'h240, 1'b1, 10'h040, 10'h240},
        {10'h000, 1'b1, 10'h200, 10'h040},
        {10'h000, 1'b1, 10'h040, 10'h000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [9:0] ev, input logic wr, input logic [31:0] wd);
        tx_done_p = ev[0]; tx_stop_p = ev[1]; tx_bufna_p = ev[2]; tx_jabber_p = ev[3];
        rx_ovf_p = ev[4]; tx_unf_p = ev[5]; rx_done_p = ev[6]; rx_stop_p = ev[8];
        rx_wdt_p = ev[9];
        reg_wr = wr; reg_wdata = wd;
        @(negedge clk);
        tx_done_p = 0; tx_stop_p = 0; tx_bufna_p = 0; tx_jabber_p = 0;
        rx_ovf_p = 0; tx_unf_p = 0; rx_done_p = 0; rx_stop_p = 0; rx_wdt_p = 0;
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic fetch(input logic own);
        rx_fetch_p = 1'b1; rx_fetch_dma_own = own;
        @(negedge clk);
        rx_fetch_p = 1'b0; rx_fetch_dma_own = 1'b0;
    endtask

    function automatic logic [31:0] img(input logic [9:0] st, input logic [2:0] ts);
        return {9'd0, ts, 10'd0, st};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", reg_rdata, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 suspend", {31'd0, tx_suspend_req}, 32'd0);

        // R2 R3 R4 R6 R9 table walk
        for (int i = 0; i < 16; i++) begin
            logic [9:0] ev, mk, ex;
            logic       wr;
            {ev, wr, mk, ex} = VEC[i];
            tx_state = i[2:0];
            drive(ev, wr, {22'd0, mk});
            chk("R4/R2/R3 status", reg_rdata, img(ex, i[2:0]));
            chk("R6 irq", {31'd0, irq}, {31'd0, ex != 10'd0});
            chk("R9 suspend", {31'd0, tx_suspend_req}, {31'd0, ex[5]});
        end

        // R5 receive buffer unavailable qualification
        fetch(1'b0);
        chk("R5 first host fetch", reg_rdata, img(10'h080, tx_state));
        drive(10'h000, 1'b1, 32'h80);
        fetch(1'b0);
        chk("R5 repeat host fetch", reg_rdata, img(10'h000, tx_state));
        fetch(1'b1);
        chk("R5 dma fetch", reg_rdata, img(10'h000, tx_state));
        fetch(1'b0);
        chk("R5 host after dma", reg_rdata, img(10'h080, tx_state));
        chk("R6 irq bit7", {31'd0, irq}, 32'd1);

        // R7 R8 writes to state and unused bits ignored, state is live
        tx_state = 3'd5;
        drive(10'h000, 1'b1, 32'hFFFF_FC00);
        chk("R8 unused ignore", reg_rdata, img(10'h080, 3'd5));
        tx_state = 3'd2;
        #1;
        chk("R7 live state", reg_rdata, img(10'h080, 3'd2));

        // R9 underflow held while a same-cycle clear collides, then released
        drive(10'h020, 1'b1, 32'h20);
        chk("R9 suspend set wins", {31'd0, tx_suspend_req}, 32'd1);
        drive(10'h000, 1'b1, 32'h0A0);
        chk("R9 suspend release", {31'd0, tx_suspend_req}, 32'd0);
        chk("R2 clear all", reg_rdata, img(10'h000, 3'd2));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule